// File: doc/BRIEF.md
# Sector Protection and Lock Controller

This block keeps the write-protection state of a serial flash array split into 64 uniform 64-Kbyte sectors. Each sector has one protection flag. The flag can be set or cleared one sector at a time, or set or cleared for every sector at once through a status-register write. A lock flag freezes every protection flag. Once the lock is set, it can only be released while the external write-protect pin is inactive.

The command front end decodes the serial traffic and presents single-cycle strobes to this block: protect one sector, unprotect one sector, and write status. With each strobe it also presents the 24-bit address, the status data byte and the state of the write-enable latch. The block answers combinationally whether a program or erase at a given address is allowed. It also reports the lock flag and a two-bit summary of how many sectors are protected. It pulses a request for the front end to clear its write-enable latch.

Top module: `sector_guard`

## Requirements
- R1: After reset every sector is protected, the lock flag is 0 and the summary reads 11.
- R2: A protect strobe with the write-enable latch high and the lock flag 0 sets the flag of the sector selected by address bits 21:16. Address bits 23:22 and 15:0 have no effect on which sector is chosen.
- R3: An unprotect strobe with the write-enable latch high and the lock flag 0 clears the flag of the sector selected by address bits 21:16.
- R4: The allow output is 1 exactly when the sector selected by bits 21:16 of the check address is unprotected. This gives the answer for both program and erase.
- R5: A strobe issued while the write-enable latch is low changes no flag, does not change the lock and causes no clear request.
- R6: While the lock flag is 1, protect and unprotect strobes leave every sector flag unchanged.
- R7: A status write while unlocked loads the lock flag from data bit 7. In the same write, data bits 5:2 equal to 1111 protect every sector and equal to 0000 unprotect every sector. Any other value of those bits leaves the sector flags unchanged.
- R8: A status write while locked and with the write-protect input active is ignored entirely: the lock stays 1 and no sector flag changes.
- R9: A status write while locked and with the write-protect input inactive loads the lock flag from data bit 7 and ignores data bits 5:2.
- R10: The summary output reads 00 when no sector is protected, 01 when some are, and 11 when all are.
- R11: The clear request output is high for one cycle after every strobe accepted with the write-enable latch high, whether or not the strobe changed any state.
- R12: When several strobes arrive in one cycle, the status write takes precedence over protect, and protect takes precedence over unprotect. Only the highest-priority strobe acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| protStb | input | 1 | Protect-one-sector strobe |
| unprotStb | input | 1 | Unprotect-one-sector strobe |
| statusWrStb | input | 1 | Status write strobe |
| wrEn | input | 1 | Write-enable latch state |
| wpActive | input | 1 | Write-protect pin, 1 = asserted |
| cmdAddr | input | 24 | Address carried by a sector command |
| statusData | input | 8 | Status write data byte |
| checkAddr | input | 24 | Address of a pending program or erase |
| allow | output | 1 | 1 when the checked address may be written |
| locked | output | 1 | Lock flag |
| swpStatus | output | 2 | Protection summary |
| wenClear | output | 1 | Request to clear the write-enable latch |

## Verification
The bench attempts to release the lock while the write-protect input is active. A design that honoured this write would let a locked array be unprotected. The bench also sends partial global patterns, which a careless decoder would treat as protect-all. It fires simultaneous strobes, where a wrong priority would unprotect a sector that should end up protected. It uses addresses with the high bits set, to catch a sector index taken from the wrong bits. It sweeps the protection count through zero, one and all sectors, so a summary that confused some with all would show 11 or 00 at the wrong time.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int LOCK_BIT = 7;
  localparam int GLB_HI = 5;
  localparam int GLB_LO = 2;

  typedef struct packed {
    logic setOne;
    logic clrOne;
    logic setAll;
    logic clrAll;
    logic lockWr;
    logic lockVal;
  } sgAct_t;
endpackage

// File: rtl/sg_ctrl.sv
module sg_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protStb,
  input  logic              unprotStb,
  input  logic              statusWrStb,
  input  logic              wrEn,
  input  logic              wpActive,
  input  logic              locked,
  input  logic [7:0]        statusData,
  output sg_pkg::sgAct_t    act,
  output logic              wenClear
);
  import sg_pkg::*;

  localparam int GLB_W = GLB_HI - GLB_LO + 1;

  logic [GLB_W-1:0] glb;
  logic anyStb;

  assign glb = statusData[GLB_HI:GLB_LO];
  assign anyStb = protStb | unprotStb | statusWrStb;

  always_comb begin
    act = '0;
    if (wrEn) begin
      if (statusWrStb) begin
        if (locked) begin
          if (!wpActive) begin
            act.lockWr = 1'b1;
            act.lockVal = statusData[LOCK_BIT];
          end
        end else begin
          act.lockWr = 1'b1;
          act.lockVal = statusData[LOCK_BIT];
          if (glb == {GLB_W{1'b1}}) act.setAll = 1'b1;
          else if (glb == '0) act.clrAll = 1'b1;
        end
      end else if (protStb) begin
        act.setOne = !locked;
      end else if (unprotStb) begin
        act.clrOne = !locked;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wenClear <= 1'b0;
    else wenClear <= wrEn & anyStb;
  end

  // R11
  wen_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    wenClear |-> $past(wrEn && (protStb || unprotStb || statusWrStb)));

  // R5
  no_wen_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !wenClear);
endmodule

// File: rtl/sg_bits.sv
module sg_bits #(
  parameter int SECTORS = 64,
  parameter int ADDR_W = 24,
  parameter int SECT_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sg_pkg::sgAct_t    act,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] checkAddr,
  output logic              allow,
  output logic              locked,
  output logic [1:0]        swpStatus
);
  localparam int SECT_W = $clog2(SECTORS);

  logic [SECTORS-1:0] protBits;
  logic [SECT_W-1:0] cmdSect;
  logic [SECT_W-1:0] chkSect;

  assign cmdSect = cmdAddr[SECT_SHIFT +: SECT_W];
  assign chkSect = checkAddr[SECT_SHIFT +: SECT_W];

  for (genvar s = 0; s < SECTORS; s++) begin : g_sect
    logic hit;
    assign hit = (cmdSect == SECT_W'(s));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) protBits[s] <= 1'b1;
      else if (act.setAll) protBits[s] <= 1'b1;
      else if (act.clrAll) protBits[s] <= 1'b0;
      else if (act.setOne && hit) protBits[s] <= 1'b1;
      else if (act.clrOne && hit) protBits[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) locked <= 1'b0;
    else if (act.lockWr) locked <= act.lockVal;
  end

  always_comb begin
    if (&protBits) swpStatus = 2'b11;
    else if (|protBits) swpStatus = 2'b01;
    else swpStatus = 2'b00;
  end

  assign allow = ~protBits[chkSect];

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(protBits));

  // R10
  all_deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swpStatus == 2'b11) |-> !allow);

  // R10
  none_allow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swpStatus == 2'b00) |-> allow);
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int SECTORS = 64,
  parameter int ADDR_W = 24,
  parameter int SECT_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protStb,
  input  logic              unprotStb,
  input  logic              statusWrStb,
  input  logic              wrEn,
  input  logic              wpActive,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        statusData,
  input  logic [ADDR_W-1:0] checkAddr,
  output logic              allow,
  output logic              locked,
  output logic [1:0]        swpStatus,
  output logic              wenClear
);
  sg_pkg::sgAct_t act;

  sg_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .protStb(protStb), .unprotStb(unprotStb),
    .statusWrStb(statusWrStb), .wrEn(wrEn), .wpActive(wpActive),
    .locked(locked), .statusData(statusData), .act(act), .wenClear(wenClear)
  );

  sg_bits #(.SECTORS(SECTORS), .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT)) i_bits (
    .clk(clk), .rstN(rstN), .act(act), .cmdAddr(cmdAddr), .checkAddr(checkAddr),
    .allow(allow), .locked(locked), .swpStatus(swpStatus)
  );

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && wpActive) |=> locked);
endmodule

// File: tb/test_sector_guard.sv
module test_sector_guard;
  localparam int CLK = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic protStb = 0, unprotStb = 0, statusWrStb = 0, wrEn = 0, wpActive = 0;
  logic [23:0] cmdAddr = '0, checkAddr = '0;
  logic [7:0] statusData = '0;
  logic allow, locked, wenClear;
  logic [1:0] swpStatus;

  int total = 0, bad = 0, cycles = 0;
  string curReq = "R1";
  bit refBits[64];
  bit refLock, refWen;

  always #(CLK/2) clk = ~clk;

  sector_guard i_sector_guard (
    .clk(clk), .rstN(rstN), .protStb(protStb), .unprotStb(unprotStb),
    .statusWrStb(statusWrStb), .wrEn(wrEn), .wpActive(wpActive),
    .cmdAddr(cmdAddr), .statusData(statusData), .checkAddr(checkAddr),
    .allow(allow), .locked(locked), .swpStatus(swpStatus), .wenClear(wenClear)
  );

  // behavioural reference
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      foreach (refBits[i]) refBits[i] = 1;
      refLock = 0;
      refWen = 0;
    end else begin
      int sec;
      sec = int'(cmdAddr[21:16]);
      refWen = wrEn && (protStb || unprotStb || statusWrStb);
      if (wrEn && statusWrStb) begin
        if (!refLock) begin
          if (statusData[5:2] == 4'b1111) foreach (refBits[i]) refBits[i] = 1;
          if (statusData[5:2] == 4'b0000) foreach (refBits[i]) refBits[i] = 0;
          refLock = statusData[7];
        end else if (!wpActive) refLock = statusData[7];
      end else if (wrEn && protStb) begin
        if (!refLock) refBits[sec] = 1;
      end else if (wrEn && unprotStb) begin
        if (!refLock) refBits[sec] = 0;
      end
    end
  end

  function automatic logic [1:0] refSwp();
    int n = 0;
    foreach (refBits[i]) n += refBits[i];
    if (n == 64) return 2'b11;
    if (n == 0) return 2'b00;
    return 2'b01;
  endfunction

  task automatic chk(string what, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cycles >= 1 && rstN) begin
      chk("locked", {1'b0, locked}, {1'b0, refLock});
      chk("swp", swpStatus, refSwp());
      chk("allow", {1'b0, allow}, {1'b0, !refBits[int'(checkAddr[21:16])]});
      chk("wenClear", {1'b0, wenClear}, {1'b0, refWen});
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic cmd(string req, logic p, logic u, logic s, logic we,
                     logic [23:0] a, logic [7:0] d);
    step();
    curReq = req;
    protStb = p; unprotStb = u; statusWrStb = s; wrEn = we;
    cmdAddr = a; statusData = d; checkAddr = a;
    step();
    protStb = 0; unprotStb = 0; statusWrStb = 0;
    step();
  endtask

  task automatic sweep(string req);
    curReq = req;
    for (int k = 0; k < 64; k += 7) begin
      step();
      checkAddr = {2'b10, 6'(k), 16'h5A5A};
    end
  endtask

  initial begin
    #(CLK*200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) step();
    rstN = 1;
    sweep("R1");
    // R3 unprotect one sector, R10 some
    cmd("R3", 0, 1, 0, 1, 24'h05ABCD, 8'h00);
    sweep("R4");
    // R5 ignored with write-enable low
    cmd("R5", 1, 0, 0, 0, 24'h050000, 8'h00);
    cmd("R5", 0, 0, 1, 0, 24'h000000, 8'h00);
    checkAddr = 24'h050000;
    step();
    // R2 protect again, top bits ignored
    cmd("R2", 1, 0, 0, 1, 24'hC5FFFF, 8'h00);
    // R7 global unprotect -> summary 00
    cmd("R7", 0, 0, 1, 1, 24'h000000, 8'h00);
    sweep("R10");
    // R7 partial pattern: no change
    cmd("R7", 0, 0, 1, 1, 24'h000000, 8'h14);
    cmd("R2", 1, 0, 0, 1, 24'hFFFFFF, 8'h00);
    sweep("R10");
    // R7 lock and global protect in one write
    cmd("R7", 0, 0, 1, 1, 24'h000000, 8'hBC);
    // R6 locked: rejected, R11 still clears write enable
    cmd("R6", 0, 1, 0, 1, 24'h030000, 8'h00);
    // R8 lock release with WP active ignored
    wpActive = 1;
    cmd("R8", 0, 0, 1, 1, 24'h000000, 8'h00);
    cmd("R11", 0, 0, 1, 1, 24'h000000, 8'h3C);
    wpActive = 0;
    // R9 release with WP inactive, pattern ignored
    cmd("R9", 0, 0, 1, 1, 24'h000000, 8'h00);
    cmd("R3", 0, 1, 0, 1, 24'h030000, 8'h00);
    // R12 priorities
    cmd("R12", 1, 1, 0, 1, 24'h030000, 8'h00);
    cmd("R12", 0, 1, 1, 1, 24'h070000, 8'h3C);
    cmd("R12", 1, 1, 1, 1, 24'h090000, 8'h00);
    // pseudo-random traffic
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wpActive = lfsr[9];
      cmd("R2", lfsr[0], lfsr[1], lfsr[2] & lfsr[3] & lfsr[4],
          lfsr[5] | lfsr[6], {lfsr[15:10], lfsr[7:6], lfsr},
          {lfsr[8], 1'b0, {4{lfsr[11]}} ^ {3'b000, lfsr[12]}, 2'b00});
    end
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule